// File: doc/BRIEF.md
# SECDED Read-Path Checker with Selectable Correction

This block sits between a flash-style memory array and its consumer. Each read returns a 64-bit data word with an 8-bit check byte. The block recomputes the check byte and classifies the read as clean, single-bit in error, or multi-bit in error. It then returns the data, corrected or raw, together with two error flags. All results are registered and appear one clock after the read strobe.

A 4-bit mode register chooses the behaviour. The value 0x5 selects detection-only operation. In that mode nothing is corrected and every error is reported as uncorrectable. Every other value selects correction, which repairs single-bit errors. A 16-bit saturating counter tallies the single-bit errors repaired in correction mode, for profiling. A dedicated input clears the counter.

Top module: `secded_read_checker`

## Requirements
- R1: Code layout. Data bit i occupies the i-th position of 3, 5, 6, 7, 9, 10 and so on: the integers from 3 upward that are not powers of two. Check bit k (k = 0..6) is the XOR of every data bit whose position has bit k set. Check bit 7 makes the XOR of all 72 bits even. A read that matches its check byte returns the data unchanged with both flags low.
- R2: `cfg_we` loads `cfg_mode` into the mode register. Reset leaves the register at 0x0, which is a correction-mode value.
- R3: In correction mode, a read with one flipped data bit returns the original data, raises `err_single` and keeps `err_multi` low.
- R4: In correction mode, a read with one flipped check bit, including check bit 7, returns the data unmodified, raises `err_single` and keeps `err_multi` low.
- R5: In correction mode, a read with two flipped bits raises `err_multi`, keeps `err_single` low and returns the data as read.
- R6: With mode 0x5, the data is returned exactly as read and `err_single` stays low. `err_multi` rises for any error, one bit or two.
- R7: With mode 0x5, a single-bit error leaves the profiling count unchanged.
- R8: `out_valid` is high exactly one cycle after each cycle with `rd_valid` high. Both flags are low whenever `out_valid` is low. After reset, `out_valid`, the flags and the count are zero.
- R9: Each single-bit error reported in correction mode adds one to `sbe_count`. The count stops at 65535.
- R10: `cnt_clr` sets `sbe_count` to zero on the next edge and takes priority over a simultaneous increment.
- R11: Mode values other than 0x5, for example 0x4, 0x6 and 0xF, behave as correction mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the mode register |
| cfg_mode | input | 4 | New mode value |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 64 | Data word from memory |
| rd_chk | input | 8 | Check byte from memory |
| cnt_clr | input | 1 | Clear the single-error count |
| out_valid | output | 1 | Result valid, one cycle after `rd_valid` |
| out_data | output | 64 | Corrected or raw data |
| err_single | output | 1 | Single-bit error seen and handled |
| err_multi | output | 1 | Uncorrectable error, or any error in detection-only mode |
| sbe_count | output | 16 | Saturating count of single-bit errors |

## Verification
A wrong check-bit position map shows up as flags on clean words, or as repair of the wrong bit. Either error appears on the very next `out_valid` after a read. A stuck or misdecoded mode register shows in the same cycle. In that case a single-bit error is repaired when it should be reported as multi-bit, or the reverse, and `sbe_count` moves when it should not. Counter faults, such as wrap-around at 65535 or lost priority of the clear, appear as a wrong `sbe_count` one edge after the offending increment.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 64;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] DETECT_ONLY = 4'h5;

  function automatic int calc_par_w(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  localparam int PAR_W = calc_par_w(DATA_W);   // Hamming check bits
  localparam int CHK_W = PAR_W + 1;            // plus overall parity
  localparam int LAST_POS = DATA_W + PAR_W;    // highest Hamming position

  typedef logic [PAR_W-1:0] syn_t;
  typedef logic [DATA_W-1:0][PAR_W-1:0] pos_tab_t;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Hamming position of each data bit: skip powers of two.
  function automatic pos_tab_t build_pos_tab();
    pos_tab_t t;
    int p;
    p = 2;
    for (int i = 0; i < DATA_W; i++) begin
      while (is_pow2(p)) p++;
      t[i] = PAR_W'(p);
      p++;
    end
    return t;
  endfunction

  localparam pos_tab_t POS_TAB = build_pos_tab();

  // XOR of positions of all set data bits = Hamming check bits.
  function automatic syn_t hamming_bits(input logic [DATA_W-1:0] d);
    syn_t s;
    s = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) s ^= POS_TAB[i];
    return s;
  endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output syn_t              syndrome_o,
  output logic              parity_odd_o
);
  // Recomputed check bits against the stored ones.
  assign syndrome_o   = hamming_bits(data_i) ^ chk_i[PAR_W-1:0];
  // Even overall parity is expected on the full codeword.
  assign parity_odd_o = ^{data_i, chk_i};
endmodule

// File: rtl/secded_classify.sv
module secded_classify
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  syn_t              syndrome_i,
  input  logic              parity_odd_i,
  output logic              clean_o,
  output logic              single_o,
  output logic              multi_o,
  output logic [DATA_W-1:0] flip_mask_o
);
  logic syn_zero;
  logic syn_in_range;

  assign syn_zero     = (syndrome_i == '0);
  assign syn_in_range = (int'(syndrome_i) <= LAST_POS);

  assign clean_o  = syn_zero && !parity_odd_i;
  // Odd parity: one flip. A zero syndrome means the overall parity bit itself.
  assign single_o = parity_odd_i && syn_in_range;
  assign multi_o  = !clean_o && !single_o;

  for (genvar g = 0; g < DATA_W; g++) begin : g_flip
    assign flip_mask_o[g] = single_o && (syndrome_i == POS_TAB[g]);
  end

  a_r4_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({clean_o, single_o, multi_o}));
  a_r3_flip_only_single: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_mask_o != '0) |-> (single_o && $onehot(flip_mask_o)));
  a_r5_even_not_single: assert property (@(posedge clk) disable iff (!rst_n)
    !parity_odd_i |-> !single_o);
endmodule

// File: rtl/secded_sat_counter.sv
module secded_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAX = '1;

  logic at_max;
  assign at_max = (count_o == MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_o <= '0;
    else if (clr_i)            count_o <= '0;
    else if (inc_i && !at_max) count_o <= count_o + 1'b1;
  end

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr_i) |=> (count_o == MAX));
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && !at_max) |=> (count_o == $past(count_o) + 1'b1));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));
endmodule

// File: rtl/secded_read_checker.sv
module secded_read_checker
  import secded_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic              cnt_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              err_single,
  output logic              err_multi,
  output logic [CNT_W-1:0]  sbe_count
);
  logic [MODE_W-1:0] mode_q;
  logic              det_mode;
  syn_t              syndrome;
  logic              parity_odd;
  logic              is_clean, is_single, is_multi;
  logic [DATA_W-1:0] flip_mask;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_single, nxt_multi;
  logic              count_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (cfg_we) mode_q <= cfg_mode;
  end

  assign det_mode = (mode_q == DETECT_ONLY);

  secded_syndrome u_syn (
    .data_i       (rd_data),
    .chk_i        (rd_chk),
    .syndrome_o   (syndrome),
    .parity_odd_o (parity_odd)
  );

  secded_classify u_cls (
    .clk          (clk),
    .rst_n        (rst_n),
    .syndrome_i   (syndrome),
    .parity_odd_i (parity_odd),
    .clean_o      (is_clean),
    .single_o     (is_single),
    .multi_o      (is_multi),
    .flip_mask_o  (flip_mask)
  );

  always_comb begin
    if (det_mode) begin
      nxt_data   = rd_data;
      nxt_single = 1'b0;
      nxt_multi  = !is_clean;
    end else begin
      nxt_data   = rd_data ^ flip_mask;
      nxt_single = is_single;
      nxt_multi  = is_multi;
    end
  end

  assign count_inc = rd_valid && nxt_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      err_single <= 1'b0;
      err_multi  <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid  <= rd_valid;
      err_single <= rd_valid && nxt_single;
      err_multi  <= rd_valid && nxt_multi;
      if (rd_valid) out_data <= nxt_data;
    end
  end

  secded_sat_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (count_inc),
    .count_o (sbe_count)
  );

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (!out_valid && !err_single && !err_multi));
  a_r6_detect_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && det_mode) |=> (out_data == $past(rd_data) && !err_single));
  a_r7_detect_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && det_mode && !cnt_clr) |=> $stable(sbe_count));
  a_r1_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && is_clean) |=> (out_data == $past(rd_data) && !err_single && !err_multi));
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    err_single |-> !err_multi);
endmodule

// File: tb/secded_read_checker_bench.sv
module secded_read_checker_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  mode;
    logic [63:0] data;
    logic [7:0]  f1;   // codeword bit to flip: 0..63 data, 64..71 check; FF none
    logic [7:0]  f2;
  } vec_t;

  // Rows: R1 clean, R3 data flips, R4 check flips, R5 doubles,
  // R6/R7 detection-only, R11 other correction values.
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 64'hA5A5_5A5A_0F0F_F0F0, 8'hFF, 8'hFF},
    '{4'h0, 64'h0123_4567_89AB_CDEF, 8'd0,  8'hFF},
    '{4'h0, 64'hFFFF_0000_FFFF_0000, 8'd63, 8'hFF},
    '{4'h0, 64'hDEAD_BEEF_CAFE_F00D, 8'd64, 8'hFF},
    '{4'h0, 64'h1111_2222_3333_4444, 8'd71, 8'hFF},
    '{4'h0, 64'h8000_0000_0000_0001, 8'd10, 8'd40},
    '{4'h0, 64'h0000_0000_0000_0000, 8'd70, 8'd71},
    '{4'h5, 64'h5555_AAAA_5555_AAAA, 8'd17, 8'hFF},
    '{4'h5, 64'h7777_8888_9999_0000, 8'd3,  8'd4},
    '{4'h5, 64'hFEDC_BA98_7654_3210, 8'hFF, 8'hFF},
    '{4'h6, 64'h0F1E_2D3C_4B5A_6978, 8'd33, 8'hFF},
    '{4'hF, 64'h1357_9BDF_2468_ACE0, 8'd70, 8'hFF},
    '{4'h4, 64'hCCCC_3333_CCCC_3333, 8'hFF, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_chk = '0;
  logic        cnt_clr = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        err_single, err_multi;
  logic [15:0] sbe_count;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int exp_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_read_checker u_secded_read_checker (
    .clk, .rst_n, .cfg_we, .cfg_mode, .rd_valid, .rd_data, .rd_chk, .cnt_clr,
    .out_valid, .out_data, .err_single, .err_multi, .sbe_count
  );

  // Independent encoder: lay the word out by position, then fold parities.
  function automatic logic [7:0] encode(input logic [63:0] d);
    logic [127:0] word;
    logic [7:0] c;
    int k;
    word = '0;
    k = 0;
    for (int pos = 1; pos <= 71; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        word[pos] = d[k];
        k++;
      end
    end
    c = '0;
    for (int b = 0; b < 7; b++)
      for (int pos = 1; pos <= 71; pos++)
        if (pos[b]) c[b] = c[b] ^ word[pos];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [71:0] flipped(input logic [63:0] d, input logic [7:0] f1,
                                          input logic [7:0] f2);
    logic [71:0] cw;
    cw = {encode(d), d};
    if (f1 != 8'hFF) cw[f1] = ~cw[f1];
    if (f2 != 8'hFF) cw[f2] = ~cw[f2];
    return cw;
  endfunction

  // One read; outputs checked at the negedge after the capturing posedge.
  task automatic read_word(input logic [71:0] cw);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_data = cw[63:0];
    rd_chk = cw[71:64];
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [71:0] cw;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!out_valid && !err_single && !err_multi, "R8 reset flags/valid",
          {61'd0, out_valid, err_single, err_multi}, 64'd0);
    check(sbe_count == 0, "R8 reset count", 64'(sbe_count), 64'd0);
    rst_n = 1'b1;

    // R2: reset mode corrects a single data-bit error
    cw = flipped(64'hAAAA_0000_5555_FFFF, 8'd20, 8'hFF);
    read_word(cw);
    check(out_valid, "R8 valid one cycle after strobe", 64'(out_valid), 64'd1);
    check(out_data == 64'hAAAA_0000_5555_FFFF && err_single && !err_multi,
          "R2 reset mode corrects", out_data, 64'hAAAA_0000_5555_FFFF);
    exp_count = 1;
    check(sbe_count == 16'(exp_count), "R9 count after one", 64'(sbe_count), 64'(exp_count));
    @(negedge clk);
    check(!out_valid && !err_single, "R8 valid drops", 64'(out_valid), 64'd0);

    // Table walk: R1 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int nerr;
      bit det;
      logic [63:0] exp_d;
      bit exp_s, exp_m;
      v = VECS[i];
      nerr = (v.f1 != 8'hFF) + (v.f2 != 8'hFF);
      det = (v.mode == 4'h5);
      cw = flipped(v.data, v.f1, v.f2);
      if (!det && nerr == 1) exp_d = v.data;
      else exp_d = cw[63:0];
      exp_s = !det && nerr == 1;
      exp_m = det ? (nerr > 0) : (nerr == 2);
      if (exp_s) exp_count++;
      set_mode(v.mode);
      read_word(cw);
      check(out_valid, $sformatf("R8 row %0d valid", i), 64'(out_valid), 64'd1);
      check(out_data == exp_d, $sformatf("R1/R3/R4/R5/R6/R11 row %0d data", i), out_data, exp_d);
      check(err_single == exp_s, $sformatf("R3/R4/R6 row %0d single flag", i),
            64'(err_single), 64'(exp_s));
      check(err_multi == exp_m, $sformatf("R5/R6 row %0d multi flag", i),
            64'(err_multi), 64'(exp_m));
      check(sbe_count == 16'(exp_count), $sformatf("R7/R9 row %0d count", i),
            64'(sbe_count), 64'(exp_count));
    end

    // R9: saturation with a continuous stream of single-bit errors
    set_mode(4'h0);
    cw = flipped(64'h0BAD_F00D_0BAD_F00D, 8'd5, 8'hFF);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_data = cw[63:0];
    rd_chk = cw[71:64];
    repeat (65540) @(negedge clk);
    rd_valid = 1'b0;
    check(sbe_count == 16'hFFFF, "R9 count saturates", 64'(sbe_count), 64'hFFFF);
    @(negedge clk);
    check(sbe_count == 16'hFFFF, "R9 count holds at max", 64'(sbe_count), 64'hFFFF);

    // R10: clear wins over a simultaneous increment
    @(negedge clk);
    cnt_clr = 1'b1;
    rd_valid = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    rd_valid = 1'b0;
    check(sbe_count == 0, "R10 clear priority", 64'(sbe_count), 64'd0);
    read_word(cw);
    check(sbe_count == 1, "R10 counts after clear", 64'(sbe_count), 64'd1);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule